// File: doc/BRIEF.md
# Prioritized Interrupt Collector

The collector watches a parameterized set of level-sensitive interrupt lines (128 by default) and drives a single request line toward a processor. Every line owns a small control word that carries an enable bit and a two-bit priority. Software updates these words through a plain address, a set alias or a clear alias, so one field can change without a read-modify-write sequence.

A combinational arbiter selects the eligible line with the highest priority and reports its number in a status register. Software enters service by writing that number to the vector register. This marks the line's priority level as in service, and the block then stops presenting requests at that level or below. Writing a one-hot level code to the level-acknowledge register ends service for a level. A self-clearing soft-reset bit in the control register returns every enable, priority and in-service flag to zero.

The register bus is a simple 32-bit port. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and has no strobe. No data stream crosses this block, so every pin is a plain control or status signal.

Top module: `irq_collector`

## Requirements
- R1: After reset `irq_req` is low, the status register at 0x70 reads all ones in its index field (7 with eight lines, 127 with 128 lines), and every control word reads zero.
- R2: The control word of line n is at 0x120 + n*0x10. Bits [1:0] hold the priority and bit 2 holds the enable. A write there replaces both fields. All other bits read as zero.
- R3: A write to 0x124 + n*0x10 ORs the written bits [2:0] into the word of line n. A write to 0x128 + n*0x10 clears the bits written as one. A read at either alias returns the word.
- R4: A line whose enable bit is zero is never presented. When no line is eligible, `irq_req` is low and status reads all ones.
- R5: Among the eligible lines, the highest priority wins, with 3 as the highest level. Within a level, the lowest line number wins. Status at 0x70 returns the winner's number.
- R6: `irq_req` is a level signal. It is high exactly while some eligible line is pending.
- R7: Writing a line number below the line count to 0x00 marks that line's priority level as in service. Larger numbers are ignored. Bit L of a read at 0x10 shows whether level L is in service.
- R8: While level L is in service, no line at level L or below is presented. A pending line at a strictly higher level is still presented.
- R9: Writing to 0x10 clears the in-service flag of every level L whose bit L is one. The value 0x1 acknowledges level 0.
- R10: Writing bit 31 at 0x20 starts a soft reset. Bit 31 reads as one for the following cycle. On the next edge all enables, priorities and in-service flags clear, and bit 31 returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_req | output | 1 | Request to the processor |

## Verification
The bench builds the collector with eight lines and two priority bits, so the full arbitration space is small enough to enumerate. Each of the 256 pending patterns is applied under three enable masks against a fixed spread of priorities. This covers every priority collision, every tie within a level and the fully masked case. With four levels, the entry and acknowledge handshake runs once per level, with an overriding request from the next higher level. The soft reset is checked on both of its cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte offsets
  localparam int unsigned OFF_VEC      = 32'h000;
  localparam int unsigned OFF_LACK     = 32'h010;
  localparam int unsigned OFF_CTRL     = 32'h020;
  localparam int unsigned OFF_STAT     = 32'h070;
  localparam int unsigned OFF_SRC_BASE = 32'h120;
  // Sub-offsets inside one line's 16-byte slot
  localparam int unsigned SUB_WORD = 0;
  localparam int unsigned SUB_SET  = 4;
  localparam int unsigned SUB_CLR  = 8;
  localparam int unsigned SRST_BIT = 31;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_WRITE,
    ACC_SET,
    ACC_CLR
  } src_acc_e;
endpackage

// File: rtl/irqc_src_regs.sv
module irqc_src_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [PRIO_W:0]           wr_bits,
  output logic [NUM_SRC-1:0]        en_o,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o,
  output logic                      rd_hit,
  output logic [31:0]               rd_word
);
  localparam int CW_W = PRIO_W + 1;
  localparam int SW   = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(OFF_SRC_BASE);

  logic [ADDR_W-1:0] rel;
  logic [SW-1:0]     slot;
  logic [3:0]        sub;
  logic              in_range;
  src_acc_e          acc;
  logic [CW_W-1:0]   word_q [NUM_SRC];

  assign rel      = bus_addr - BASE_A;
  assign slot     = rel[ADDR_W-1:4];
  assign sub      = rel[3:0];
  assign in_range = (bus_addr >= BASE_A) && (slot < SW'(NUM_SRC));

  always_comb begin
    acc = ACC_NONE;
    if (in_range) begin
      case (sub)
        4'(SUB_WORD): acc = ACC_WRITE;
        4'(SUB_SET):  acc = ACC_SET;
        4'(SUB_CLR):  acc = ACC_CLR;
        default:      acc = ACC_NONE;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit;
    assign hit = bus_wr && (acc != ACC_NONE) && (slot == SW'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[n] <= '0;
      end else if (clr_all) begin
        word_q[n] <= '0;
      end else if (hit) begin
        case (acc)
          ACC_WRITE: word_q[n] <= wr_bits;
          ACC_SET:   word_q[n] <= word_q[n] | wr_bits;
          ACC_CLR:   word_q[n] <= word_q[n] & ~wr_bits;
          default:   word_q[n] <= word_q[n];
        endcase
      end
    end

    assign en_o[n]                     = word_q[n][PRIO_W];
    assign prio_o[n*PRIO_W +: PRIO_W]  = word_q[n][PRIO_W-1:0];
  end

  assign rd_hit = (acc != ACC_NONE);

  always_comb begin
    rd_word = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (slot == SW'(n)) rd_word = 32'(word_q[n]);
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 2
) (
  input  logic [NUM_SRC-1:0]          elig,
  input  logic [NUM_SRC*PRIO_W-1:0]   prio,
  input  logic [(1<<PRIO_W)-1:0]      lvl_allow,
  output logic                        req,
  output logic [$clog2(NUM_SRC)-1:0]  sel_idx
);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int IDX_W  = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] lvl_mask [LEVELS];
  logic [IDX_W-1:0]   lvl_idx  [LEVELS];
  logic [LEVELS-1:0]  lvl_hit;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
      assign lvl_mask[l][n] = elig[n] && (prio[n*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign lvl_hit[l] = |lvl_mask[l];
    assign lvl_idx[l] = lowest_set(lvl_mask[l]);
  end

  // Ascending scan: the last admitted level, the highest, wins
  always_comb begin
    req     = 1'b0;
    sel_idx = '1;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_hit[l] && lvl_allow[l]) begin
        req     = 1'b1;
        sel_idx = lvl_idx[l];
      end
    end
  end
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc #(
  parameter int PRIO_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_all,
  input  logic                   vec_wr,
  input  logic [PRIO_W-1:0]      vec_lvl,
  input  logic                   ack_wr,
  input  logic [(1<<PRIO_W)-1:0] ack_bits,
  output logic [(1<<PRIO_W)-1:0] svc_o,
  output logic [(1<<PRIO_W)-1:0] lvl_allow
);
  localparam int LEVELS = 1 << PRIO_W;

  logic [LEVELS-1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (ack_wr) svc_d = svc_d & ~ack_bits;
    if (vec_wr) svc_d = svc_d | (LEVELS'(1) << vec_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       svc_q <= '0;
    else if (clr_all) svc_q <= '0;
    else              svc_q <= svc_d;
  end

  // A level is admitted only if it and every level above it are idle
  for (genvar l = 0; l < LEVELS; l++) begin : g_allow
    assign lvl_allow[l] = ~|svc_q[LEVELS-1:l];
  end

  assign svc_o = svc_q;
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_req
);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int IDX_W  = $clog2(NUM_SRC);

  logic                      srst_q;
  logic [NUM_SRC-1:0]        en_w;
  logic [NUM_SRC*PRIO_W-1:0] prio_w;
  logic                      src_rd_hit;
  logic [31:0]               src_word;
  logic [LEVELS-1:0]         svc_w, allow_w;
  logic [IDX_W-1:0]          sel_w;
  logic                      req_w;
  logic                      hit_vec, hit_lack, hit_ctrl, hit_stat;
  logic                      vec_wr, ack_wr;
  logic [PRIO_W-1:0]         vec_lvl;

  assign hit_vec  = bus_addr == ADDR_W'(OFF_VEC);
  assign hit_lack = bus_addr == ADDR_W'(OFF_LACK);
  assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      srst_q <= 1'b0;
    else if (srst_q) srst_q <= 1'b0;
    else if (bus_wr && hit_ctrl && bus_wdata[SRST_BIT]) srst_q <= 1'b1;
  end

  assign vec_wr  = bus_wr && hit_vec && !srst_q && (bus_wdata < 32'(NUM_SRC));
  assign vec_lvl = prio_w[bus_wdata[IDX_W-1:0]*PRIO_W +: PRIO_W];
  assign ack_wr  = bus_wr && hit_lack && !srst_q;

  irqc_src_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (srst_q),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_bits  (bus_wdata[PRIO_W:0]),
    .en_o     (en_w),
    .prio_o   (prio_w),
    .rd_hit   (src_rd_hit),
    .rd_word  (src_word)
  );

  irqc_svc #(.PRIO_W(PRIO_W)) u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (srst_q),
    .vec_wr    (vec_wr),
    .vec_lvl   (vec_lvl),
    .ack_wr    (ack_wr),
    .ack_bits  (bus_wdata[LEVELS-1:0]),
    .svc_o     (svc_w),
    .lvl_allow (allow_w)
  );

  irqc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig      (irq_src & en_w),
    .prio      (prio_w),
    .lvl_allow (allow_w),
    .req       (req_w),
    .sel_idx   (sel_w)
  );

  assign irq_req = req_w;

  always_comb begin
    bus_rdata = '0;
    if (hit_lack)        bus_rdata = 32'(svc_w);
    else if (hit_ctrl)   bus_rdata[SRST_BIT] = srst_q;
    else if (hit_stat)   bus_rdata = 32'(sel_w);
    else if (src_rd_hit) bus_rdata = src_word;
  end
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        irq_src,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_wdata,
  input logic                      irq_req,
  input logic [$clog2(NUM_SRC)-1:0] sel_idx,
  input logic [NUM_SRC-1:0]        en_vec,
  input logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input logic [(1<<PRIO_W)-1:0]    svc,
  input logic                      srst
);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int IDX_W  = $clog2(NUM_SRC);

  logic [PRIO_W-1:0] top_svc, sel_prio, wr_lvl;
  logic              svc_any, lack_wr, vec_ok;

  always_comb begin
    top_svc = '0;
    for (int l = 0; l < LEVELS; l++) if (svc[l]) top_svc = PRIO_W'(l);
  end
  assign svc_any  = |svc;
  assign sel_prio = prio_flat[sel_idx*PRIO_W +: PRIO_W];
  assign wr_lvl   = prio_flat[bus_wdata[IDX_W-1:0]*PRIO_W +: PRIO_W];
  assign lack_wr  = bus_wr && (bus_addr == ADDR_W'(32'h010)) && !srst;
  assign vec_ok   = bus_wr && (bus_addr == ADDR_W'(32'h000)) && !srst &&
                    (bus_wdata < 32'(NUM_SRC));

  // R4
  presented_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_vec[sel_idx] && irq_src[sel_idx]));

  // R6
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_src & en_vec) == '0) |-> !irq_req);

  // R8
  svc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && svc_any) |-> (sel_prio > top_svc));

  // R7
  vec_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ok |=> svc[$past(wr_lvl)]);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lack_wr |=> ((svc & $past(bus_wdata[LEVELS-1:0])) == '0));

  // R10
  srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> ((en_vec == '0) && (svc == '0) && !srst));
endmodule

bind irq_collector irq_collector_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_src   (irq_src),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_req   (irq_req),
  .sel_idx   (sel_w),
  .en_vec    (en_w),
  .prio_flat (prio_w),
  .svc       (svc_w),
  .srst      (srst_q)
);

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int N  = 8;
  localparam int PW = 2;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_VEC = 12'h000, A_LACK = 12'h010,
                            A_CTRL = 12'h020, A_STAT = 12'h070;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_src = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  irq_collector #(.NUM_SRC(N), .PRIO_W(PW), .ADDR_W(AW)) u_irq_collector (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  function automatic logic [AW-1:0] word_a(int n, int sub);
    return AW'(32'h120 + n * 16 + sub);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p [N];
    logic [7:0] en_set [3];
    en_set[0] = 8'hFF; en_set[1] = 8'hA5; en_set[2] = 8'h00;
    for (int n = 0; n < N; n++) p[n] = (n * 5 + 1) % 4;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d);
    check(irq_req == 1'b0 && d == 32'd7, "R1", {31'd0, irq_req} | d, 32'd7);
    for (int n = 0; n < N; n++) begin
      rd(word_a(n, 0), d);
      check(d == 0, "R1", d, 0);
    end

    // R2 plain write replaces, upper bits read zero
    wr(word_a(3, 0), 32'hFFFF_FFFF);
    rd(word_a(3, 0), d); check(d == 32'h7, "R2", d, 32'h7);
    wr(word_a(3, 0), 32'h2);
    rd(word_a(3, 0), d); check(d == 32'h2, "R2", d, 32'h2);

    // R3 set and clear aliases
    wr(word_a(3, 4), 32'h4);
    rd(word_a(3, 4), d); check(d == 32'h6, "R3", d, 32'h6);
    wr(word_a(3, 4), 32'h1);
    rd(word_a(3, 8), d); check(d == 32'h7, "R3", d, 32'h7);
    wr(word_a(3, 8), 32'h2);
    rd(word_a(3, 0), d); check(d == 32'h5, "R3", d, 32'h5);
    wr(word_a(3, 8), 32'hFFFF_FFFF);
    rd(word_a(3, 0), d); check(d == 32'h0, "R3", d, 32'h0);

    // R4 R5 R6 sweep over every pending pattern
    for (int e = 0; e < 3; e++) begin
      for (int n = 0; n < N; n++) wr(word_a(n, 0), 32'(p[n] | (en_set[e][n] << 2)));
      for (int pat = 0; pat < 256; pat++) begin
        int best_l;
        int best_i;
        logic [31:0] exp_s;
        irq_src = 8'(pat);
        best_l = -1; best_i = 7;
        for (int l = 3; l >= 0; l--) begin
          for (int n = N - 1; n >= 0; n--) begin
            if (best_l < 0 || best_l == l) begin
              if (pat[n] && en_set[e][n] && p[n] == l) begin
                best_l = l; best_i = n;
              end
            end
          end
        end
        exp_s = 32'(best_i);
        rd(A_STAT, d);
        if (best_l < 0)
          check(!irq_req && d == 32'd7, "R4 R6 idle", d, 32'd7);
        else
          check(irq_req && d == exp_s, "R5 R6 winner", d, exp_s);
      end
    end
    irq_src = '0;

    // R7 R8 R9 entry and exit per level
    for (int n = 0; n < N; n++) wr(word_a(n, 0), (n < 4) ? 32'(4 | n) : 32'd0);
    for (int v = 0; v < 4; v++) begin
      irq_src = 8'((1 << (v + 1)) - 1);
      rd(A_STAT, d); check(irq_req && d == 32'(v), "R5", d, 32'(v));
      wr(A_VEC, 32'(v));
      rd(A_LACK, d); check(d == 32'(1 << v), "R7", d, 32'(1 << v));
      check(irq_req == 1'b0, "R8 blocked", {31'd0, irq_req}, 0);
      if (v < 3) begin
        irq_src = 8'((1 << (v + 2)) - 1);
        rd(A_STAT, d);
        check(irq_req && d == 32'(v + 1), "R8 higher", d, 32'(v + 1));
        irq_src = 8'((1 << (v + 1)) - 1);
      end
      wr(A_LACK, 32'(1 << v));
      rd(A_LACK, d); check(d == 0, "R9", d, 0);
      rd(A_STAT, d); check(irq_req && d == 32'(v), "R9 resumed", d, 32'(v));
    end
    wr(A_VEC, 32'd8);
    rd(A_LACK, d); check(d == 0, "R7 out of range", d, 0);

    // R10 soft reset
    irq_src = 8'h0F;
    wr(A_VEC, 32'd3);
    wr(A_CTRL, 32'h8000_0000);
    rd(A_CTRL, d); check(d == 32'h8000_0000, "R10 pulse", d, 32'h8000_0000);
    @(negedge clk);
    rd(A_CTRL, d); check(d == 0, "R10 self clear", d, 0);
    rd(A_LACK, d); check(d == 0, "R10 svc", d, 0);
    for (int n = 0; n < 4; n++) begin
      rd(word_a(n, 0), d); check(d == 0, "R10 word", d, 0);
    end
    rd(A_STAT, d); check(!irq_req && d == 32'd7, "R10 idle", d, 32'd7);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule